// File: doc/BRIEF.md
# Multi-format audio transmit serializer

This block turns 32-bit sample words taken from a FIFO into serial audio on one data line per stereo channel pair. An external bit-clock tick paces it: each tick advances the bit slot by one position. A frame is 64 slots, made of a left half of 32 slots followed by a right half of 32 slots. The block drives the word-select line, or for PCM formats a one-slot frame-sync pulse, together with the data lines. Clock generation and receive are handled elsewhere.

Five layouts share one datapath. The I2S family covers the delayed-MSB, left-aligned and right-aligned layouts. The PCM family covers a pulse layout with late data and a pulse layout with data in the pulse slot. The valid sample width and the number of active lanes are programmable. While a frame is being sent, a fetch stage pops the words for the next frame from the FIFO. At each frame start the whole set is transferred to the output stage at once. When the set is incomplete at that moment, the frame is sent as silence.

Top module: `aud_tx_serializer`

## Requirements
- R1: While `xfer_en` is low, `fifo_pop` stays low, `sdo` is all zero and `ws` is low. Ticks have no effect. The cycle after `xfer_en` goes low, `sdo` and `ws` are low.
- R2: Each frame takes exactly 2*(`pairs`+1) words from the FIFO. `fifo_pop` high with `fifo_valid` high transfers one word in that cycle. Word k of a frame goes to lane k/2, to the left half when k is even and to the right half when k is odd.
- R3: With `fmt_pcm`=0 and `i2s_mode`=0 or 3 (delayed layout), slot 0 of each half is low and the sample MSB is in slot 1. A 32-bit sample therefore loses its LSB.
- R4: With `fmt_pcm`=0 and `i2s_mode`=1 (left-aligned layout), the sample MSB is in slot 0 of each half.
- R5: With `fmt_pcm`=0 and `i2s_mode`=2 (right-aligned layout), the sample LSB is in slot 31 of each half and the slots before the sample are low.
- R6: With `fmt_pcm`=1, `ws` is high only in frame slot 0. When `pcm_mode` bit 0 is 0, data starts in slot 1 of each half. When `pcm_mode` bit 0 is 1, data starts in slot 0 of each half.
- R7: The sample width is `vdw`+1 bits, taken from the low bits of the word. It is sent MSB first, and every slot outside the sample is low.
- R8: Lanes 0 to `pairs` carry data. The remaining lanes stay low.
- R9: With `fmt_pcm`=0, `ws` is low during the left half (frame slots 0 to 31) and high during the right half (slots 32 to 63).
- R10: When fewer than 2*(`pairs`+1) words are staged at a frame start, that frame sends zeros on every lane. The words already staged are kept for a later frame.
- R11: The first tick after `xfer_en` rises selects frame slot 0. Each later tick advances the slot by one, and the slot wraps from 63 to 0. Between ticks the outputs hold. The outputs change in the clock cycle of the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Transfer enable |
| fmt_pcm | input | 1 | Format family: 0 I2S family, 1 PCM family |
| i2s_mode | input | 2 | I2S-family layout: 0 delayed, 1 left-aligned, 2 right-aligned, 3 delayed |
| pcm_mode | input | 2 | PCM layout, bit 0: 0 late data, 1 data in pulse slot |
| vdw | input | 5 | Sample width minus one |
| pairs | input | 2 | Active channel pairs minus one |
| bclk_tick | input | 1 | Bit-clock enable, one cycle per bit slot |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_data | input | 32 | FIFO head word |
| fifo_pop | output | 1 | Word taken from the FIFO this cycle |
| sdo | output | 4 | Serial data, one line per channel pair |
| ws | output | 1 | Word select, or frame-sync pulse in PCM formats |

## Verification
The assertions assume that the format, width and pair fields change only while `xfer_en` is low. They also assume that `bclk_tick` is a single-cycle pulse, and that the FIFO head word stays put until it is popped. The bench changes the configuration only between runs, with the enable low. It spaces ticks three cycles apart and changes FIFO data only at the falling edge after a pop. It gives the fetch stage time to fill before the first tick, except in the silence case, where it deliberately keeps the FIFO empty.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    typedef enum logic [1:0] {
        AL_LATE  = 2'd0,
        AL_EDGE  = 2'd1,
        AL_RIGHT = 2'd2
    } align_e;

    typedef struct packed {
        logic       pcm;
        logic [1:0] ifmt;
        logic [1:0] pmode;
    } fmt_t;

    function automatic align_e fmt_align(fmt_t f);
        if (f.pcm) begin
            return f.pmode[0] ? AL_EDGE : AL_LATE;
        end
        case (f.ifmt)
            2'd1:    return AL_EDGE;
            2'd2:    return AL_RIGHT;
            default: return AL_LATE;
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_timing.sv
module aud_tx_timing #(
    parameter int SLOTS_HALF = 32,
    localparam int FRAME = 2 * SLOTS_HALF,
    localparam int CNT_W = $clog2(FRAME)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_en,
    input  logic             tick,
    output logic             run,
    output logic [CNT_W-1:0] pos,
    output logic             load
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);

    assign load = xfer_en && tick && (!run || pos == LAST);

    always_ff @(posedge clk) begin
        if (rst || !xfer_en) begin
            run <= 1'b0;
            pos <= '0;
        end else if (tick) begin
            if (!run) begin
                run <= 1'b1;
                pos <= '0;
            end else begin
                pos <= (pos == LAST) ? '0 : pos + 1'b1;
            end
        end
    end

    // R11: slot steps by one per tick while running
    p_pos_step_r11: assert property (@(posedge clk) disable iff (rst)
        (run && tick && xfer_en && pos != LAST) |=> (run && pos == $past(pos) + 1'b1));
    // R11: frame wraps to slot 0
    p_pos_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        (run && tick && xfer_en && pos == LAST) |=> (run && pos == '0));
    // R11: position holds between ticks
    p_pos_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && xfer_en) |=> $stable(pos));
endmodule

// File: rtl/aud_tx_fetch.sv
module aud_tx_fetch #(
    parameter int NLANE  = 4,
    parameter int WORD_W = 32,
    localparam int NWORD  = 2 * NLANE,
    localparam int FILL_W = $clog2(NWORD + 1),
    localparam int IDX_W  = $clog2(NWORD),
    localparam int PAIR_W = $clog2(NLANE)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         xfer_en,
    input  logic [PAIR_W-1:0]            pairs,
    input  logic                         fifo_valid,
    input  logic [WORD_W-1:0]            fifo_data,
    input  logic                         load,
    output logic                         fifo_pop,
    output logic                         full,
    output logic [NWORD-1:0][WORD_W-1:0] stage
);
    logic [FILL_W-1:0] fill;
    logic [FILL_W-1:0] need;

    assign need     = FILL_W'(2 * (int'(pairs) + 1));
    assign full     = (fill >= need);
    assign fifo_pop = xfer_en && fifo_valid && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill  <= '0;
            stage <= '0;
        end else if (!xfer_en) begin
            fill <= '0;
        end else if (load && full) begin
            fill <= '0;
        end else if (fifo_pop) begin
            stage[fill[IDX_W-1:0]] <= fifo_data;
            fill <= fill + 1'b1;
        end
    end

    // R2: staging never holds more than one frame of words
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
        fill <= need);
    // R2: a complete set is consumed at the frame start
    p_load_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (load && full) |=> (fill == '0));
    // R10: an incomplete set survives the frame start
    p_keep_partial_r10: assert property (@(posedge clk) disable iff (rst)
        (load && !full && xfer_en) |=> (fill >= $past(fill)));
    // R1: disabling drops the staged set
    p_idle_empty_r1: assert property (@(posedge clk) disable iff (rst)
        !xfer_en |=> (fill == '0));
endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift
    import aud_tx_pkg::*;
#(
    parameter int NLANE      = 4,
    parameter int WORD_W     = 32,
    parameter int SLOTS_HALF = 32,
    localparam int NWORD  = 2 * NLANE,
    localparam int CNT_W  = $clog2(2 * SLOTS_HALF),
    localparam int SLOT_W = $clog2(SLOTS_HALF),
    localparam int PAIR_W = $clog2(NLANE),
    localparam int VDW_W  = $clog2(WORD_W)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic [CNT_W-1:0]             pos,
    input  logic                         load,
    input  logic                         full,
    input  logic [NWORD-1:0][WORD_W-1:0] stage,
    input  fmt_t                         fmt,
    input  logic [VDW_W-1:0]             vdw,
    input  logic [PAIR_W-1:0]            pairs,
    output logic [NLANE-1:0]             sdo,
    output logic                         ws
);
    logic [NWORD-1:0][WORD_W-1:0] active;
    logic                         half;
    logic [SLOT_W-1:0]            slot;
    align_e                       align;

    assign half  = pos[CNT_W-1];
    assign slot  = pos[SLOT_W-1:0];
    assign align = fmt_align(fmt);

    function automatic logic slot_bit(logic [WORD_W-1:0] word,
                                      logic [SLOT_W-1:0] s_in,
                                      logic [VDW_W-1:0]  w_m1,
                                      align_e            al);
        int s = int'(s_in);
        int w = int'(w_m1) + 1;
        int j;
        logic [WORD_W-1:0] sh;
        if (al == AL_RIGHT) begin
            j = SLOTS_HALF - 1 - s;
        end else begin
            j = w - 1 - (s - ((al == AL_LATE) ? 1 : 0));
        end
        if (j < 0 || j >= w) begin
            return 1'b0;
        end
        sh = word >> j;
        return sh[0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (load) begin
            active <= full ? stage : '0;
        end
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [WORD_W-1:0] cur;
        logic              lane_on;
        assign cur      = half ? active[2*l+1] : active[2*l];
        assign lane_on  = (int'(pairs) >= l);
        assign sdo[l]   = run && lane_on && slot_bit(cur, slot, vdw, align);
    end

    assign ws = run && (fmt.pcm ? (pos == '0) : half);
endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
    import aud_tx_pkg::*;
#(
    parameter int NLANE      = 4,
    parameter int WORD_W     = 32,
    parameter int SLOTS_HALF = 32,
    localparam int PAIR_W = $clog2(NLANE),
    localparam int VDW_W  = $clog2(WORD_W),
    localparam int CNT_W  = $clog2(2 * SLOTS_HALF),
    localparam int NWORD  = 2 * NLANE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_en,
    input  logic              fmt_pcm,
    input  logic [1:0]        i2s_mode,
    input  logic [1:0]        pcm_mode,
    input  logic [VDW_W-1:0]  vdw,
    input  logic [PAIR_W-1:0] pairs,
    input  logic              bclk_tick,
    input  logic              fifo_valid,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic [NLANE-1:0]  sdo,
    output logic              ws
);
    fmt_t                         fmt;
    logic                         run;
    logic                         load;
    logic                         full;
    logic [CNT_W-1:0]             pos;
    logic [NWORD-1:0][WORD_W-1:0] stage;

    assign fmt = '{pcm: fmt_pcm, ifmt: i2s_mode, pmode: pcm_mode};

    aud_tx_timing #(.SLOTS_HALF(SLOTS_HALF)) u_timing (
        .clk(clk), .rst(rst), .xfer_en(xfer_en), .tick(bclk_tick),
        .run(run), .pos(pos), .load(load)
    );

    aud_tx_fetch #(.NLANE(NLANE), .WORD_W(WORD_W)) u_fetch (
        .clk(clk), .rst(rst), .xfer_en(xfer_en), .pairs(pairs),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .load(load),
        .fifo_pop(fifo_pop), .full(full), .stage(stage)
    );

    aud_tx_shift #(.NLANE(NLANE), .WORD_W(WORD_W), .SLOTS_HALF(SLOTS_HALF)) u_shift (
        .clk(clk), .rst(rst), .run(run), .pos(pos), .load(load), .full(full),
        .stage(stage), .fmt(fmt), .vdw(vdw), .pairs(pairs),
        .sdo(sdo), .ws(ws)
    );

    // R1: one cycle after the enable drops, the line is quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !xfer_en |=> (sdo == '0 && !ws));
endmodule

// File: tb/aud_tx_serializer_tb.sv
`timescale 1ns/1ps
module aud_tx_serializer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_en = 1'b0;
    logic        fmt_pcm = 1'b0;
    logic [1:0]  i2s_mode = '0;
    logic [1:0]  pcm_mode = '0;
    logic [4:0]  vdw = 5'd15;
    logic [1:0]  pairs = '0;
    logic        bclk_tick = 1'b0;
    logic        fifo_valid = 1'b0;
    logic [31:0] fifo_data = '0;
    logic        fifo_pop;
    logic [3:0]  sdo;
    logic        ws;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [3:0] sdo;
        logic       ws;
        string      tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] feed_q[$];
    logic        tick_seen = 1'b0;
    logic        pop_now;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    aud_tx_serializer u_dut (
        .clk(clk), .rst(rst), .xfer_en(xfer_en), .fmt_pcm(fmt_pcm),
        .i2s_mode(i2s_mode), .pcm_mode(pcm_mode), .vdw(vdw), .pairs(pairs),
        .bclk_tick(bclk_tick), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .sdo(sdo), .ws(ws)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // FIFO model: head changes only at the falling edge after a pop
    initial begin
        forever begin
            @(negedge clk);
            fifo_valid = (feed_q.size() > 0);
            fifo_data  = (feed_q.size() > 0) ? feed_q[0] : 32'h0;
            #1;
            pop_now = fifo_pop;
            @(posedge clk);
            if (pop_now && feed_q.size() > 0) void'(feed_q.pop_front());
        end
    end

    // monitor
    always @(posedge clk) tick_seen <= bclk_tick;
    always @(negedge clk) begin
        if (tick_seen) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected tick", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, {27'h0, ws, sdo}, {27'h0, e.ws, e.sdo});
            end
        end
    end

    task automatic do_tick(exp_t e);
        @(negedge clk);
        bclk_tick = 1'b1;
        exp_q.push_back(e);
        @(negedge clk);
        bclk_tick = 1'b0;
        @(negedge clk);
    endtask

    // expected 32-slot stream of one half, built from the layout rules
    function automatic logic [31:0] half_stream(logic [31:0] word, int w, bit pcm,
                                                 int im, int pm);
        logic [31:0] arr = '0;
        int start;
        if (!pcm && im == 2)            start = 32 - w;
        else if (!pcm && im == 1)       start = 0;
        else if (pcm && (pm % 2) == 1)  start = 0;
        else                            start = 1;
        for (int i = 0; i < w; i++) begin
            if (start + i < 32) arr[start + i] = word[w - 1 - i];
        end
        return arr;
    endfunction

    task automatic tick_frame(logic [31:0] words[8], bit silent, bit pcm, int im,
                              int pm, int w, int np, string tag);
        for (int p = 0; p < 64; p++) begin
            exp_t e;
            int   h = p / 32;
            int   s = p % 32;
            e.sdo = '0;
            for (int l = 0; l < 4; l++) begin
                if (l < np && !silent) begin
                    logic [31:0] st;
                    st = half_stream(words[2*l + h], w, pcm, im, pm);
                    e.sdo[l] = st[s];
                end
            end
            e.ws  = pcm ? (p == 0) : (h == 1);
            e.tag = tag;
            do_tick(e);
        end
    endtask

    task automatic play(bit pcm, int im, int pm, int vd, int pr, int nframes, string tag);
        logic [31:0] words[8];
        logic [31:0] all[$];
        int need = 2 * (pr + 1);
        @(negedge clk);
        xfer_en  = 1'b0;
        fmt_pcm  = pcm;
        i2s_mode = 2'(im);
        pcm_mode = 2'(pm);
        vdw      = 5'(vd);
        pairs    = 2'(pr);
        for (int i = 0; i < nframes * need; i++) begin
            all.push_back($urandom);
            feed_q.push_back(all[i]);
        end
        repeat (2) @(negedge clk);
        xfer_en = 1'b1;
        repeat (12) @(negedge clk);
        for (int f = 0; f < nframes; f++) begin
            for (int k = 0; k < 8; k++) words[k] = (k < need) ? all[f*need + k] : 32'h0;
            tick_frame(words, 1'b0, pcm, im, pm, vd + 1, pr + 1, tag);
        end
        repeat (3) @(negedge clk);
        check({"R2 words left in FIFO ", tag}, feed_q.size(), 0);
        xfer_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: one cycle after disable the lines are quiet
        check("R1 quiet after disable", {27'h0, ws, sdo}, 32'h0);
    endtask

    initial begin
        #(4 * 150000);
        check("watchdog expired", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] words[8];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", {26'h0, fifo_pop, ws, sdo}, 32'h0);

        play(1'b0, 0, 0, 15, 0, 2, "R3 R7 R8 R9 R11 R2 i2s 16b 1 pair");
        play(1'b0, 1, 0, 23, 1, 2, "R4 R7 R8 R9 left-aligned 24b 2 pairs");
        play(1'b0, 2, 0, 15, 3, 2, "R5 R7 R8 R2 right-aligned 16b 4 pairs");
        play(1'b0, 2, 0, 31, 0, 1, "R5 R7 right-aligned 32b");
        play(1'b1, 0, 0, 19, 0, 2, "R6 R7 pcm late 20b");
        play(1'b1, 0, 1, 31, 2, 2, "R6 R7 R8 pcm edge 32b 3 pairs");
        play(1'b1, 0, 2, 7, 1, 1, "R6 pcm mode 2 as late");
        play(1'b0, 0, 0, 31, 1, 1, "R3 i2s 32b loses LSB");
        play(1'b0, 3, 0, 11, 0, 1, "R3 i2s mode 3 as delayed");

        // R10: empty FIFO at frame start gives a silent frame, then data
        @(negedge clk);
        fmt_pcm = 1'b0; i2s_mode = 2'd0; pcm_mode = 2'd0; vdw = 5'd15; pairs = 2'd0;
        xfer_en = 1'b1;
        repeat (12) @(negedge clk);
        for (int k = 0; k < 8; k++) words[k] = 32'h0;
        words[0] = 32'h0000_A5C3;
        words[1] = 32'h0000_3C5A;
        for (int p = 0; p < 64; p++) begin
            exp_t e;
            e.sdo = '0;
            e.ws  = (p >= 32);
            e.tag = "R10 silent frame";
            if (p == 10) begin
                feed_q.push_back(words[0]);
            end
            do_tick(e);
        end
        check("R10 partial word staged", feed_q.size(), 0);
        feed_q.push_back(words[1]);
        repeat (4) @(negedge clk);
        tick_frame(words, 1'b0, 1'b0, 0, 0, 16, 1, "R10 kept word used next frame");
        xfer_en = 1'b0;

        // R1: disabled block ignores FIFO and ticks
        repeat (3) @(negedge clk);
        feed_q.push_back(32'hFFFF_FFFF);
        feed_q.push_back(32'hFFFF_FFFF);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1;
            check("R1 no pop while disabled", {31'h0, fifo_pop}, 32'h0);
        end
        for (int i = 0; i < 4; i++) begin
            exp_t e;
            e.sdo = '0; e.ws = 1'b0; e.tag = "R1 ticks ignored while disabled";
            do_tick(e);
        end
        check("R1 FIFO untouched", feed_q.size(), 2);
        feed_q.delete();

        repeat (4) @(negedge clk);
        check("R11 no missing samples", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule